// File: doc/BRIEF.md
# Hebbian Crossbar Synapse Array

This block is a grid of signed synaptic weights joining a layer of presynaptic neurons (rows) to a layer of postsynaptic neurons (columns). In each cycle every postsynaptic neuron adds up the weights of the rows that are firing. It fires on the next cycle when that total is above zero. A row that is not firing adds nothing to the total.

Each weight is stored as an unsigned offset-binary code. The midpoint code stands for zero. Codes above the midpoint push the column toward firing, and codes below it hold the column back.

Learning happens in place. A programming pulse on a row line and a column line moves only the weight at the cell where both are asserted. The move is one code step, up or down as a shared polarity input selects. The weight stops at the ends of its code range, so every pulse has the same effect until the weight saturates.

Top module: `hebb_xbar`

## Requirements
- R1: After reset every weight holds the midpoint code 32 (with the default 6-bit width) and post_fire is all zero.
- R2: At each clock edge, post_fire[j] is loaded with 1 exactly when the signed sum over firing rows i of (weight[i][j] - 32) is strictly greater than 0.
- R3: A row whose pre_fire bit is 0 adds nothing to any column sum. With pre_fire all zero, post_fire is all zero on the next cycle.
- R4: weight[i][j] changes at a clock edge only when row_pulse[i] and col_pulse[j] are both 1 in that cycle. All other cells keep their value.
- R5: A pulse at a crossing with pol_up = 1 adds exactly 1 to the weight. With pol_up = 0 it subtracts exactly 1. The step is the same for every starting value.
- R6: The weight saturates: an increment at 63 leaves it at 63, and a decrement at 0 leaves it at 0.
- R7: The firing decision made at an edge uses the weights held before that edge. A weight updated at the same edge first affects post_fire one edge later.
- R8: A column sum of exactly zero, such as all rows firing on midpoint weights, does not fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_fire | input | N_PRE | Presynaptic fire bits, one per row |
| row_pulse | input | N_PRE | Programming pulse line for each row |
| col_pulse | input | N_POST | Programming pulse line for each column |
| pol_up | input | 1 | Update polarity: 1 increments, 0 decrements |
| post_fire | output | N_POST | Registered postsynaptic fire bits, one per column |

## Verification
The step and saturation properties assume that row, column and polarity inputs are stable and defined at each sampling edge. They also assume that a pulse at a crossing acts on that cell alone. The bench drives every input half a period away from the rising edge and holds it for the whole cycle, so these conditions are always met.

Weights are visible only through the fire outputs. The stimulus therefore pairs pulse bursts with single-row probes, and it mixes sparse random pulses with random fire patterns. This drives weights to both rails and through the zero-sum boundary, while a bench model tracks every cell.

// File: rtl/hebb_pkg.sv
package hebb_pkg;
  typedef enum logic {
    POL_DEC = 1'b0,
    POL_INC = 1'b1
  } pol_e;
endpackage

// File: rtl/hebb_cell.sv
module hebb_cell #(
  parameter int W_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_pulse,
  input  logic              col_pulse,
  input  logic              pol_up,
  output logic [W_BITS-1:0] w_q
);
  import hebb_pkg::*;

  localparam int MID  = 1 << (W_BITS - 1);
  localparam int WMAX = (1 << W_BITS) - 1;

  logic              step_en;
  logic [W_BITS-1:0] w_d;

  // A cell only learns where its row line and its column line cross.
  assign step_en = row_pulse & col_pulse;

  always_comb begin
    w_d = w_q;
    if (pol_e'(pol_up) == POL_INC) begin
      if (w_q != W_BITS'(WMAX)) w_d = w_q + 1'b1;
    end else begin
      if (w_q != '0) w_d = w_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       w_q <= W_BITS'(MID);
    else if (step_en) w_q <= w_d;
  end

  AST_HOLD_OFF_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_pulse && col_pulse) |=> $stable(w_q)); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_pulse && col_pulse && pol_up && w_q != W_BITS'(WMAX)) |=> (w_q == $past(w_q) + 1'b1)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (row_pulse && col_pulse && !pol_up && w_q != '0) |=> (w_q == $past(w_q) - 1'b1)); // R5
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_pulse && col_pulse && pol_up && w_q == W_BITS'(WMAX)) |=> (w_q == W_BITS'(WMAX))); // R6
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (row_pulse && col_pulse && !pol_up && w_q == '0) |=> (w_q == '0)); // R6
endmodule

// File: rtl/hebb_neuron.sv
module hebb_neuron #(
  parameter int N_PRE  = 4,
  parameter int W_BITS = 6
) (
  input  logic [N_PRE-1:0]             pre_fire,
  input  logic [N_PRE-1:0][W_BITS-1:0] wts,
  output logic                         fire_d
);
  localparam int MID   = 1 << (W_BITS - 1);
  localparam int SUM_W = W_BITS + $clog2(N_PRE) + 1;

  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] term;

  // Offset-binary weights become signed terms. Idle rows give zero.
  always_comb begin
    acc = '0;
    for (int i = 0; i < N_PRE; i++) begin
      term = $signed(SUM_W'(wts[i])) - $signed(SUM_W'(MID));
      if (pre_fire[i]) acc = acc + term;
    end
  end

  // Strictly positive total: sign bit clear and not zero.
  assign fire_d = !acc[SUM_W-1] && (acc != '0);
endmodule

// File: rtl/hebb_xbar.sv
module hebb_xbar #(
  parameter int N_PRE  = 4,
  parameter int N_POST = 3,
  parameter int W_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PRE-1:0]  pre_fire,
  input  logic [N_PRE-1:0]  row_pulse,
  input  logic [N_POST-1:0] col_pulse,
  input  logic              pol_up,
  output logic [N_POST-1:0] post_fire
);
  logic [N_PRE-1:0][W_BITS-1:0] col_w [N_POST];
  logic [N_POST-1:0]            fire_d;

  for (genvar j = 0; j < N_POST; j++) begin : g_col
    for (genvar i = 0; i < N_PRE; i++) begin : g_row
      logic [W_BITS-1:0] w_q;
      hebb_cell #(.W_BITS(W_BITS)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_pulse (row_pulse[i]),
        .col_pulse (col_pulse[j]),
        .pol_up    (pol_up),
        .w_q       (w_q)
      );
      assign col_w[j][i] = w_q;
    end
    hebb_neuron #(.N_PRE(N_PRE), .W_BITS(W_BITS)) u_neuron (
      .pre_fire (pre_fire),
      .wts      (col_w[j]),
      .fire_d   (fire_d[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_fire <= '0;
    else        post_fire <= fire_d;
  end

  AST_QUIET_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fire == '0) |=> (post_fire == '0)); // R3
endmodule

// File: tb/tb_hebb_xbar.sv
module tb_hebb_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NQ = 3;
  localparam int WMAX = 63;
  localparam int MID = 32;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pre_fire;
  logic [NP-1:0] row_pulse;
  logic [NQ-1:0] col_pulse;
  logic          pol_up;
  logic [NQ-1:0] post_fire;

  int checks = 0;
  int errors = 0;
  int mw [NQ][NP];
  logic [NQ-1:0] exp_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  hebb_xbar #(.N_PRE(NP), .N_POST(NQ), .W_BITS(6)) dut (
    .clk(clk), .rst_n(rst_n), .pre_fire(pre_fire), .row_pulse(row_pulse),
    .col_pulse(col_pulse), .pol_up(pol_up), .post_fire(post_fire)
  );

  function automatic logic [NQ-1:0] model_fire(logic [NP-1:0] pf);
    logic [NQ-1:0] r;
    for (int j = 0; j < NQ; j++) begin
      int s = 0;
      for (int i = 0; i < NP; i++) if (pf[i]) s += mw[j][i] - MID;
      r[j] = (s > 0);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [NQ-1:0] act, logic [NQ-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, model the edge, compare one half period later.
  task automatic cyc(string tag, logic [NP-1:0] pf, logic [NP-1:0] rp,
                     logic [NQ-1:0] cp, logic up, bit do_check);
    pre_fire = pf; row_pulse = rp; col_pulse = cp; pol_up = up;
    @(posedge clk);
    exp_q = model_fire(pf);
    for (int j = 0; j < NQ; j++)
      for (int i = 0; i < NP; i++)
        if (rp[i] && cp[j]) begin
          if (up) mw[j][i] = (mw[j][i] == WMAX) ? WMAX : mw[j][i] + 1;
          else    mw[j][i] = (mw[j][i] == 0) ? 0 : mw[j][i] - 1;
        end
    @(negedge clk);
    if (do_check) check(tag, post_fire, exp_q);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < NQ; j++) for (int i = 0; i < NP; i++) mw[j][i] = MID;
    rst_n = 1'b0; pre_fire = '0; row_pulse = '0; col_pulse = '0; pol_up = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset output", post_fire, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 / R1: all rows fire on midpoint weights, zero sum
    cyc("R8 zero sum all rows", 4'b1111, '0, '0, 1'b0, 1);
    // R3: nothing firing
    cyc("R3 idle rows", 4'b0000, '0, '0, 1'b0, 1);
    // R5: one up pulse at row0/col0, then probe row0 alone
    cyc("R5 pulse", 4'b0000, 4'b0001, 3'b001, 1'b1, 1);
    cyc("R5 single step fires col0 only", 4'b0001, '0, '0, 1'b0, 1);
    // R6: saturate row0/col0 at the top
    for (int k = 0; k < 40; k++) cyc("R6 up burst", 4'b0000, 4'b0001, 3'b001, 1'b1, 0);
    cyc("R6 top rail probe", 4'b0001, '0, '0, 1'b0, 1);
    // R4: other cells untouched, row1 probe gives zero
    cyc("R4 untouched row1", 4'b0010, '0, '0, 1'b0, 1);
    // R6: drive to bottom
    for (int k = 0; k < 70; k++) cyc("R6 down burst", 4'b0000, 4'b0001, 3'b001, 1'b0, 0);
    cyc("R6 bottom rail probe", 4'b0001, '0, '0, 1'b0, 1);
    // Row1/col0 to 33
    cyc("R5 row1 step", 4'b0000, 4'b0010, 3'b001, 1'b1, 1);
    cyc("R2 mixed sum negative", 4'b0011, '0, '0, 1'b0, 1);
    cyc("R3 idle row0 ignored", 4'b0010, '0, '0, 1'b0, 1);
    // R7: decrement row1/col0 at the same edge as the probe
    cyc("R7 old weight used", 4'b0010, 4'b0010, 3'b001, 1'b0, 1);
    cyc("R7 new weight next edge", 4'b0010, '0, '0, 1'b0, 1);
    // R4: pulse rows 2,3 and col2 only, then probe col1 stays unaffected
    cyc("R4 partial cross", 4'b0000, 4'b1100, 3'b100, 1'b1, 1);
    cyc("R4 crossing probe", 4'b1100, '0, '0, 1'b0, 1);
    // Random phase checked against the model (R2)
    for (int k = 0; k < 3000; k++) begin
      logic [NP-1:0] pf, rp;
      logic [NQ-1:0] cp;
      pf = NP'($urandom);
      rp = NP'($urandom) & NP'($urandom);
      cp = NQ'($urandom) & NQ'($urandom);
      cyc("R2 random", pf, rp, cp, 1'($urandom), 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule